// File: doc/BRIEF.md
# Select-Coded Three-Register Datapath

This block is a small register-transfer datapath with three 8-bit registers. Each register has its own short menu of operations and its own select input. The first register (`r1`) can be cleared, kept, or loaded with a bitwise mix of input B and the third register. The second register (`r2`) can be cleared, kept, loaded from input A, or doubled by a one-place left shift. The third register (`r3`) can be cleared, kept, or loaded with the sum of input C and the second register. No sequencer sits inside the block. An external controller drives the three select codes on every cycle, and each code is acted on at the next rising clock edge.

Two outputs leave the block. The main result is the third register. The second output is a full-width product of input A and the first register, formed without any register stage. Every operation that updates a register reads the register values from before the edge, so all three registers can change in the same cycle without interfering with each other.

Top module: `tri_reg_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, all three registers become zero. After that edge, `y_out` is 0 and `prod_out` is 0 for any `din_a`.
- R2: `sel_r1` selects the next value of `r1`. Code 0 clears it. Codes 1 and 3 keep it. Code 2 loads `din_b XOR r3`, where `r3` is the value before the edge.
- R3: `sel_r2` selects the next value of `r2`. Code 0 clears it. Code 1 keeps it. Code 2 loads `din_a`. Code 3 loads the old `r2` shifted left by one place, with a 0 entering at bit 0.
- R4: `sel_r3` selects the next value of `r3`. Code 0 clears it. Codes 1 and 3 keep it. Code 2 loads `din_c + r2`, where `r2` is the value before the edge.
- R5: `y_out` always shows the current value of `r3`.
- R6: `prod_out` is the unsigned 16-bit product of `din_a` and the current `r1`. It follows `din_a` within the same cycle.
- R7: When several registers update at one edge, each one uses only the register values from before that edge.
- R8: The shift and the sum keep only the low 8 bits. The shift drops bit 7 of the old `r2`, and the sum wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of all registers |
| sel_r1 | input | 2 | Operation code for `r1` |
| sel_r2 | input | 2 | Operation code for `r2` |
| sel_r3 | input | 2 | Operation code for `r3` |
| din_a | input | 8 | Load source for `r2`; multiplicand for `prod_out` |
| din_b | input | 8 | Operand mixed with `r3` into `r1` |
| din_c | input | 8 | Addend combined with `r2` into `r3` |
| y_out | output | 8 | Current `r3` |
| prod_out | output | 16 | `din_a` times `r1` |

## Verification
The hardest state to see from the ports is `r2`, because it drives no output directly. It shows up only one edge later, through the sum path into `r3` with `din_c` held at zero. `r1` is read in the same way, by setting `din_a` to 1 so that the product equals `r1`. The stimulus reaches these states by sweeping all 64 combinations of the three select codes under several data patterns, while a bench model tracks every register. Directed sequences add the cases that need a chosen register history: a shift that drops the top bit, a sum that wraps, and an edge where all three registers update from each other's old values. Each sequence ends with a readout step that brings the register out to a port.

// File: rtl/trd_pkg.sv
package trd_pkg;

   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      R1_CLR  = 2'd0,
      R1_KEEP = 2'd1,
      R1_MIX  = 2'd2,
      R1_IDLE = 2'd3
   } r1_op_e;

   typedef enum logic [SEL_W-1:0] {
      R2_CLR  = 2'd0,
      R2_KEEP = 2'd1,
      R2_LOAD = 2'd2,
      R2_DBL  = 2'd3
   } r2_op_e;

   typedef enum logic [SEL_W-1:0] {
      R3_CLR  = 2'd0,
      R3_KEEP = 2'd1,
      R3_SUM  = 2'd2,
      R3_IDLE = 2'd3
   } r3_op_e;

   localparam int MUL_OPERATOR = 0;
   localparam int MUL_SHIFTADD = 1;

endpackage

// File: rtl/trd_reg.sv
module trd_reg #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          ld,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         q <= '0;
      end else if (ld) begin
         q <= d;
      end
   end

endmodule

// File: rtl/trd_ops.sv
module trd_ops #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] op_b,
   input  logic [DW-1:0] op_c,
   input  logic [DW-1:0] r2_cur,
   input  logic [DW-1:0] r3_cur,
   output logic [DW-1:0] mix_o,
   output logic [DW-1:0] dbl_o,
   output logic [DW-1:0] sum_o
);

   // Function unit: bitwise combination of B with the third register
   assign mix_o = op_b ^ r3_cur;

   // Left shifter: drops the top bit, zero enters at bit 0
   assign dbl_o = {r2_cur[DW-2:0], 1'b0};

   // Adder: wraps at the datapath width
   assign sum_o = op_c + r2_cur;

endmodule

// File: rtl/trd_mul.sv
module trd_mul #(
   parameter int DW   = 8,
   parameter int ARCH = 1
) (
   input  logic [DW-1:0]   op_a,
   input  logic [DW-1:0]   op_b,
   output logic [2*DW-1:0] prod_o
);

   localparam int PW = 2 * DW;

   generate
      if (ARCH == 0) begin : g_operator
         assign prod_o = PW'(op_a) * PW'(op_b);
      end else begin : g_shiftadd
         logic [PW-1:0] acc [0:DW];
         assign acc[0] = '0;
         for (genvar i = 0; i < DW; i++) begin : g_row
            logic [PW-1:0] pp;
            assign pp         = op_b[i] ? (PW'(op_a) << i) : '0;
            assign acc[i + 1] = acc[i] + pp;
         end
         assign prod_o = acc[DW];
      end
   endgenerate

endmodule

// File: rtl/tri_reg_datapath.sv
module tri_reg_datapath #(
   parameter int DW       = 8,
   parameter int MUL_ARCH = 1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [trd_pkg::SEL_W-1:0] sel_r1,
   input  logic [trd_pkg::SEL_W-1:0] sel_r2,
   input  logic [trd_pkg::SEL_W-1:0] sel_r3,
   input  logic [DW-1:0]             din_a,
   input  logic [DW-1:0]             din_b,
   input  logic [DW-1:0]             din_c,
   output logic [DW-1:0]             y_out,
   output logic [2*DW-1:0]           prod_out
);

   import trd_pkg::*;

   localparam int PW = 2 * DW;

   generate
      if (DW < 2 || DW > 64) begin : g_bad_width
         $error("tri_reg_datapath: DW must lie in 2..64");
      end
      if (MUL_ARCH != MUL_OPERATOR && MUL_ARCH != MUL_SHIFTADD) begin : g_bad_arch
         $error("tri_reg_datapath: MUL_ARCH must be 0 or 1");
      end
   endgenerate

   logic [DW-1:0] r1_q, r2_q, r3_q;
   logic [DW-1:0] mix_w, dbl_w, sum_w;
   logic          r1_clr, r1_ld, r2_clr, r2_ld, r3_clr, r3_ld;
   logic [DW-1:0] r1_d, r2_d, r3_d;

   trd_ops #(.DW(DW)) u_ops (
      .op_b   (din_b),
      .op_c   (din_c),
      .r2_cur (r2_q),
      .r3_cur (r3_q),
      .mix_o  (mix_w),
      .dbl_o  (dbl_w),
      .sum_o  (sum_w)
   );

   // Per-register next-value selection
   always_comb begin
      r1_clr = 1'b0;
      r1_ld  = 1'b0;
      r1_d   = mix_w;
      case (r1_op_e'(sel_r1))
         R1_CLR:  r1_clr = 1'b1;
         R1_MIX:  r1_ld  = 1'b1;
         default: ;
      endcase
   end

   always_comb begin
      r2_clr = 1'b0;
      r2_ld  = 1'b0;
      r2_d   = dbl_w;
      case (r2_op_e'(sel_r2))
         R2_CLR:  r2_clr = 1'b1;
         R2_LOAD: begin
            r2_ld = 1'b1;
            r2_d  = din_a;
         end
         R2_DBL:  r2_ld  = 1'b1;
         default: ;
      endcase
   end

   always_comb begin
      r3_clr = 1'b0;
      r3_ld  = 1'b0;
      r3_d   = sum_w;
      case (r3_op_e'(sel_r3))
         R3_CLR:  r3_clr = 1'b1;
         R3_SUM:  r3_ld  = 1'b1;
         default: ;
      endcase
   end

   trd_reg #(.DW(DW)) u_r1 (
      .clk (clk), .rst (rst), .clr (r1_clr), .ld (r1_ld), .d (r1_d), .q (r1_q)
   );

   trd_reg #(.DW(DW)) u_r2 (
      .clk (clk), .rst (rst), .clr (r2_clr), .ld (r2_ld), .d (r2_d), .q (r2_q)
   );

   trd_reg #(.DW(DW)) u_r3 (
      .clk (clk), .rst (rst), .clr (r3_clr), .ld (r3_ld), .d (r3_d), .q (r3_q)
   );

   logic [PW-1:0] prod_w;

   trd_mul #(.DW(DW), .ARCH(MUL_ARCH)) u_mul (
      .op_a   (din_a),
      .op_b   (r1_q),
      .prod_o (prod_w)
   );

   assign y_out    = r3_q;
   assign prod_out = prod_w;

endmodule

// File: rtl/trd_checker.sv
module trd_checker #(
   parameter int DW = 8
) (
   input logic            clk,
   input logic            rst,
   input logic [1:0]      sel_r1,
   input logic [1:0]      sel_r2,
   input logic [1:0]      sel_r3,
   input logic [DW-1:0]   din_a,
   input logic [DW-1:0]   din_b,
   input logic [DW-1:0]   din_c,
   input logic [DW-1:0]   y_out,
   input logic [2*DW-1:0] prod_out,
   input logic [DW-1:0]   r1_q,
   input logic [DW-1:0]   r2_q
);

   AST_RST_CLEAR: assert property (@(posedge clk)
      rst |=> (r1_q == '0 && r2_q == '0 && y_out == '0))
      else $error("reset did not clear registers"); // R1

   AST_R1_MIX: assert property (@(posedge clk) disable iff (rst)
      (sel_r1 == 2'd2) |=> (r1_q == ($past(din_b) ^ $past(y_out))))
      else $error("r1 mix load wrong"); // R2

   AST_R1_KEEP: assert property (@(posedge clk) disable iff (rst)
      (sel_r1 == 2'd1 || sel_r1 == 2'd3) |=> $stable(r1_q))
      else $error("r1 not kept"); // R2

   AST_R2_LOAD: assert property (@(posedge clk) disable iff (rst)
      (sel_r2 == 2'd2) |=> (r2_q == $past(din_a)))
      else $error("r2 load wrong"); // R3

   AST_R2_SHIFT: assert property (@(posedge clk) disable iff (rst)
      (sel_r2 == 2'd3) |=> (r2_q == {$past(r2_q[DW-2:0]), 1'b0}))
      else $error("r2 shift wrong"); // R8

   AST_R3_SUM: assert property (@(posedge clk) disable iff (rst)
      (sel_r3 == 2'd2) |=> (y_out == DW'($past(din_c) + $past(r2_q))))
      else $error("r3 sum wrong"); // R7

   AST_R3_KEEP: assert property (@(posedge clk) disable iff (rst)
      (sel_r3 == 2'd1 || sel_r3 == 2'd3) |=> $stable(y_out))
      else $error("y_out moved on keep"); // R5

   AST_R3_CLR: assert property (@(posedge clk) disable iff (rst)
      (sel_r3 == 2'd0) |=> (y_out == '0))
      else $error("r3 not cleared"); // R4

   AST_PROD_UNIT: assert property (@(posedge clk) disable iff (rst)
      (din_a == DW'(1)) |-> (prod_out == (2*DW)'(r1_q)))
      else $error("product with unit A wrong"); // R6

   AST_PROD_ZERO: assert property (@(posedge clk) disable iff (rst)
      (r1_q == '0) |-> (prod_out == '0))
      else $error("product with zero r1 wrong"); // R6

endmodule

bind tri_reg_datapath trd_checker #(.DW(DW)) u_trd_chk (
   .clk      (clk),
   .rst      (rst),
   .sel_r1   (sel_r1),
   .sel_r2   (sel_r2),
   .sel_r3   (sel_r3),
   .din_a    (din_a),
   .din_b    (din_b),
   .din_c    (din_c),
   .y_out    (y_out),
   .prod_out (prod_out),
   .r1_q     (r1_q),
   .r2_q     (r2_q)
);

// File: tb/tri_reg_datapath_tb.sv
module tri_reg_datapath_tb;

   localparam int DW       = 8;
   localparam int CLK_PER  = 10;
   localparam int WATCHDOG = 200000;

   logic          clk = 1'b0;
   logic          rst;
   logic [1:0]    sel_r1, sel_r2, sel_r3;
   logic [DW-1:0] din_a, din_b, din_c;
   logic [DW-1:0] y_out;
   logic [15:0]   prod_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [DW-1:0] m1 = '0, m2 = '0, m3 = '0;

   always #(CLK_PER / 2) clk = ~clk;

   tri_reg_datapath #(.DW(DW)) u_dut (
      .clk      (clk),
      .rst      (rst),
      .sel_r1   (sel_r1),
      .sel_r2   (sel_r2),
      .sel_r3   (sel_r3),
      .din_a    (din_a),
      .din_b    (din_b),
      .din_c    (din_c),
      .y_out    (y_out),
      .prod_out (prod_out)
   );

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, check at the next falling edge
   task automatic step(input logic [1:0] s1, input logic [1:0] s2, input logic [1:0] s3,
                       input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] c,
                       input string ytag, input string ptag);
      logic [DW-1:0] n1, n2, n3;
      logic [15:0]   pe;
      sel_r1 = s1; sel_r2 = s2; sel_r3 = s3;
      din_a  = a;  din_b  = b;  din_c  = c;
      n1 = (s1 == 2'd0) ? '0 : (s1 == 2'd2) ? (b ^ m3) : m1;
      case (s2)
         2'd0:    n2 = '0;
         2'd1:    n2 = m2;
         2'd2:    n2 = a;
         default: n2 = DW'({1'b0, m2} * 2);
      endcase
      n3 = (s3 == 2'd0) ? '0 : (s3 == 2'd2) ? DW'(int'(c) + int'(m2)) : m3;
      @(posedge clk);
      m1 = n1; m2 = n2; m3 = n3;
      @(negedge clk);
      pe = 16'(int'(a) * int'(m1));
      chk(16'(y_out), 16'(m3), ytag);
      chk(prod_out, pe, ptag);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      rst = 1'b1;
      sel_r1 = 2'd2; sel_r2 = 2'd2; sel_r3 = 2'd2;
      din_a = 8'hFF; din_b = 8'hA5; din_c = 8'h3C;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: registers cleared despite load codes
      chk(16'(y_out), 16'h0000, "R1");
      chk(prod_out, 16'h0000, "R1");
      rst = 1'b0;
      // R1: r2 reads back as zero through the sum path
      step(2'd1, 2'd1, 2'd2, 8'h01, 8'h00, 8'h00, "R1", "R1");

      // R3: load A, then read r2 through sum with C=0
      step(2'd1, 2'd2, 2'd1, 8'h5A, 8'h00, 8'h00, "R5", "R6");
      step(2'd1, 2'd1, 2'd2, 8'h00, 8'h00, 8'h00, "R3", "R6");
      step(2'd1, 2'd0, 2'd1, 8'h00, 8'h00, 8'h00, "R3", "R6");
      step(2'd1, 2'd1, 2'd2, 8'h00, 8'h00, 8'h07, "R3", "R6");

      // R2: mix load, then read r1 with A=1 under hold codes 3 and 1, then clear
      step(2'd2, 2'd1, 2'd1, 8'h01, 8'hC3, 8'h00, "R4", "R2");
      step(2'd3, 2'd1, 2'd1, 8'h01, 8'h00, 8'h00, "R4", "R2");
      step(2'd1, 2'd1, 2'd3, 8'h01, 8'h00, 8'h00, "R4", "R2");
      step(2'd0, 2'd1, 2'd0, 8'h01, 8'h00, 8'h00, "R4", "R2");

      // R8: shift drops bit 7
      step(2'd1, 2'd2, 2'd1, 8'h81, 8'h00, 8'h00, "R8", "R6");
      step(2'd1, 2'd3, 2'd1, 8'h00, 8'h00, 8'h00, "R8", "R6");
      step(2'd1, 2'd1, 2'd2, 8'h00, 8'h00, 8'h00, "R8", "R6");
      // R8: sum wraps modulo 256
      step(2'd1, 2'd2, 2'd1, 8'hF0, 8'h00, 8'h00, "R8", "R6");
      step(2'd1, 2'd1, 2'd2, 8'h00, 8'h00, 8'h20, "R8", "R6");

      // R7: all three update together from old values
      step(2'd2, 2'd3, 2'd2, 8'h00, 8'h0F, 8'h01, "R7", "R7");
      step(2'd1, 2'd1, 2'd1, 8'h01, 8'h00, 8'h00, "R7", "R7");
      step(2'd1, 2'd1, 2'd2, 8'h01, 8'h00, 8'h00, "R7", "R7");

      // R4 R5 R6: sweep of every select combination under several data patterns
      for (int s = 0; s < 64; s++) begin
         for (int k = 0; k < 4; k++) begin
            step(2'(s), 2'(s >> 2), 2'(s >> 4),
                 DW'(s * 37 + k * 91 + 5), DW'(s * 53 + k * 29 + 17), DW'(s * 11 + k * 173 + 200),
                 "R4", "R6");
         end
      end

      // R1: reset in mid-run
      rst = 1'b1;
      sel_r1 = 2'd1; sel_r2 = 2'd1; sel_r3 = 2'd1;
      @(posedge clk);
      m1 = '0; m2 = '0; m3 = '0;
      @(negedge clk);
      rst = 1'b0;
      chk(16'(y_out), 16'h0000, "R1");
      step(2'd1, 2'd1, 2'd2, 8'hFF, 8'h00, 8'h00, "R1", "R1");

      done = 1'b1;
      finish_run();
   end

endmodule